// File: doc/BRIEF.md
# MDIO Frame-Word Management Master

This block drives the MII management bus (MDC clock and bidirectional MDIO data) from a small register interface. Software prepares a full 32-bit management frame in one word. That word already holds the start pattern, the opcode, the PHY and register addresses, the turnaround pair and the 16-bit data field. Software first writes the MDC divider register and then writes the frame word. The block sends a preamble of 32 ones and then the frame, most significant bit first.

For a read frame, the block releases MDIO from the turnaround pair onward. It samples the 16 bits returned by the PHY and places them in the low half of the frame/data register. At the end of every frame, the block sets a sticky completion flag. Software clears that flag by writing a one to it. A busy bit can be read while a frame is in flight.

The register map has three words, selected by `bus_addr`:

- 0: the frame/data register.
- 1: the MDC divider.
- 2: the event/status word. Bit 0 is the completion flag and bit 1 is busy.

Reads are combinational. A write takes effect at the clock edge on which `bus_we` is high.

Top module: `mdio_fw_master`

## Requirements
- R1: After reset, `mdc_o` is low, `mdio_oe` is low, `evt_o` is low, and reads of addresses 0, 1 and 2 return zero.
- R2: A write to address 0 while idle, with a nonzero divider, loads the word into the frame/data register and starts a frame. Busy (address 2, bit 1) reads 1 from the next cycle until the frame ends.
- R3: A frame consists of 64 bit periods: 32 ones, then frame bits 31 down to 0. Each bit is driven while MDC is low and is held unchanged while MDC is high.
- R4: MDC has a period of 2*(divider+1) system clocks and is low whenever no frame is running. The completion flag rises exactly 128*(divider+1) cycles after the starting write edge.
- R5: A frame word whose bits 29:28 equal binary 10 is a read. From frame bit 17 onward, MDIO is released for the last 18 bit periods. `mdio_i` is sampled on the 16 rising MDC edges of frame bits 15..0, most significant first. The sampled bits replace bits 15:0 of the frame/data register, and bits 31:16 are kept.
- R6: Any other opcode is a write. All 64 bit periods are driven, and the frame/data register keeps the written word.
- R7: Address 2, bit 0 (mirrored on `evt_o`) sets when a frame ends. It stays set until a write to address 2 with bit 0 equal to 1. A write with bit 0 equal to 0 leaves it set.
- R8: While the divider is 0, a write to address 0 is ignored: no frame starts, MDC stays low, and the register keeps its old value.
- R9: The divider (address 1, 6 bits) may be rewritten at any time. On an idle bus it causes no MDC edge. A frame uses the divider value captured when it started.
- R10: A write to address 0 while busy is ignored, both on the bus and in the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select (0 frame/data, 1 divider, 2 event/status) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| evt_o | output | 1 | Sticky completion flag |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (0 = released) |
| mdio_i | input | 1 | MDIO input from the bus |

## Verification
The hardest situation to reach is the one where the captured divider and the register value differ. This needs a divider rewrite and a second frame-word write while a frame is already in flight. The stimulus starts a frame with a short divider, then writes a much larger divider and a different frame word mid-frame. The checks then confirm three things: the total duration still follows the old divider, the serial bits still follow the first word, and the register still holds the first word. The read turnaround is exercised by a bench-side PHY model. It counts MDC rising edges and presents data only after the release point.

// File: rtl/mdio_fw_pkg.sv
package mdio_fw_pkg;
  localparam int PRE_BITS = 32;
  localparam int FRM_BITS = 32;
  localparam int TOT_BITS = PRE_BITS + FRM_BITS;
  localparam int IDX_W    = $clog2(TOT_BITS);
  localparam int DAT_BITS = 16;
  // bit period index at which a read frame releases the line (frame bit 17)
  localparam int REL_IDX  = PRE_BITS + (FRM_BITS - DAT_BITS - 2);
  // first bit period whose rising edge carries returned data (frame bit 15)
  localparam int CAP_IDX  = PRE_BITS + (FRM_BITS - DAT_BITS);

  localparam logic [1:0] A_FRAME = 2'd0;
  localparam logic [1:0] A_DIV   = 2'd1;
  localparam logic [1:0] A_EVT   = 2'd2;

  function automatic logic fw_is_read(input logic [FRM_BITS-1:0] w);
    return w[29:28] == 2'b10;
  endfunction

  function automatic int fw_frame_cycles(input int div);
    return TOT_BITS * 2 * (div + 1);
  endfunction
endpackage

// File: rtl/mdio_fw_clkgen.sv
module mdio_fw_clkgen #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_evt,
  output logic             fall_evt
);
  logic [DIV_W-1:0] cnt;
  logic             half_end;

  assign half_end = run && (cnt == div);
  assign rise_evt = half_end && !mdc;
  assign fall_evt = half_end && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (half_end) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_fw_shifter.sv
module mdio_fw_shifter
  import mdio_fw_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [FRM_BITS-1:0] frame,
  input  logic                rise_evt,
  input  logic                fall_evt,
  input  logic                mdio_i,
  output logic                busy,
  output logic                rd_frame,
  output logic [IDX_W-1:0]    bit_idx,
  output logic                mdio_o,
  output logic                mdio_oe,
  output logic [DAT_BITS-1:0] cap,
  output logic                fin_evt
);
  logic [FRM_BITS-1:0] frame_q;
  logic [4:0]          fpos;
  logic                in_pre;

  assign in_pre   = bit_idx < IDX_W'(PRE_BITS);
  assign fpos     = 5'(FRM_BITS - 1) - bit_idx[4:0];
  assign rd_frame = fw_is_read(frame_q);
  assign fin_evt  = fall_evt && (bit_idx == IDX_W'(TOT_BITS - 1));
  assign mdio_o   = busy && (in_pre ? 1'b1 : frame_q[fpos]);
  assign mdio_oe  = busy && !(rd_frame && bit_idx >= IDX_W'(REL_IDX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      bit_idx <= '0;
      frame_q <= '0;
      cap     <= '0;
    end else if (!busy) begin
      if (start) begin
        busy    <= 1'b1;
        bit_idx <= '0;
        frame_q <= frame;
      end
    end else begin
      if (rise_evt && rd_frame && bit_idx >= IDX_W'(CAP_IDX))
        cap <= {cap[DAT_BITS-2:0], mdio_i};
      if (fin_evt) begin
        busy    <= 1'b0;
        bit_idx <= '0;
      end else if (fall_evt) begin
        bit_idx <= bit_idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mdio_fw_master.sv
module mdio_fw_master
  import mdio_fw_pkg::*;
#(
  parameter int DIV_W = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        evt_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic [FRM_BITS-1:0] data_reg;
  logic [DIV_W-1:0]    div_reg;
  logic [DIV_W-1:0]    div_act;
  logic                evt_q;
  logic                busy;
  logic                rd_frame;
  logic [IDX_W-1:0]    bit_idx;
  logic [DAT_BITS-1:0] cap;
  logic                fin_evt;
  logic                rise_evt;
  logic                fall_evt;
  logic                start_go;
  logic                evt_clr;

  assign start_go = bus_we && bus_addr == A_FRAME && !busy && div_reg != '0;
  assign evt_clr  = bus_we && bus_addr == A_EVT && bus_wdata[0];
  assign evt_o    = evt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_reg <= '0;
      div_reg  <= '0;
      div_act  <= '0;
      evt_q    <= 1'b0;
    end else begin
      if (bus_we && bus_addr == A_DIV) div_reg <= bus_wdata[DIV_W-1:0];
      if (start_go) begin
        data_reg <= bus_wdata;
        div_act  <= div_reg;
      end else if (fin_evt && rd_frame) begin
        data_reg[DAT_BITS-1:0] <= cap;
      end
      if (fin_evt)      evt_q <= 1'b1;
      else if (evt_clr) evt_q <= 1'b0;
    end
  end

  always_comb begin
    case (bus_addr)
      A_FRAME: bus_rdata = data_reg;
      A_DIV:   bus_rdata = 32'(div_reg);
      A_EVT:   bus_rdata = {30'd0, busy, evt_q};
      default: bus_rdata = '0;
    endcase
  end

  mdio_fw_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(busy), .div(div_act),
    .mdc(mdc_o), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  mdio_fw_shifter u_shf (
    .clk(clk), .rst_n(rst_n), .start(start_go), .frame(bus_wdata),
    .rise_evt(rise_evt), .fall_evt(fall_evt), .mdio_i(mdio_i),
    .busy(busy), .rd_frame(rd_frame), .bit_idx(bit_idx),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .cap(cap), .fin_evt(fin_evt)
  );
endmodule

// File: rtl/mdio_fw_chk.sv
module mdio_fw_chk
  import mdio_fw_pkg::*;
#(
  parameter int DIV_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_we,
  input logic [1:0]       bus_addr,
  input logic [31:0]      bus_wdata,
  input logic             evt_o,
  input logic             mdc_o,
  input logic             mdio_o,
  input logic             mdio_oe,
  input logic             busy,
  input logic             rd_frame,
  input logic [IDX_W-1:0] bit_idx,
  input logic             fin_evt,
  input logic [DIV_W-1:0] div_reg
);
  a_r4_mdc_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc_o);

  a_r3_hold_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc_o && $past(mdc_o)) |-> (mdio_o == $past(mdio_o) && mdio_oe == $past(mdio_oe)));

  a_r5_release_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_frame && bit_idx >= IDX_W'(REL_IDX)) |-> !mdio_oe);

  a_r7_sticky_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_o && !(bus_we && bus_addr == A_EVT && bus_wdata[0])) |=> evt_o);

  a_r7_set_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
    fin_evt |=> (evt_o && !busy));

  a_r8_zero_div_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_FRAME && div_reg == '0 && !busy) |=> !busy);

  a_r3_drive_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> busy);
endmodule

bind mdio_fw_master mdio_fw_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .evt_o(evt_o), .mdc_o(mdc_o), .mdio_o(mdio_o),
  .mdio_oe(mdio_oe), .busy(busy), .rd_frame(rd_frame), .bit_idx(bit_idx),
  .fin_evt(fin_evt), .div_reg(div_reg)
);

// File: tb/sim_mdio_fw_master.sv
`timescale 1ns/1ps
module sim_mdio_fw_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        evt_o, mdc_o, mdio_o, mdio_oe, mdio_i;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int rises = 0;
  logic [15:0] resp = 16'h0;
  logic sent [64];
  logic drv  [64];

  always #10 clk = ~clk;
  always @(posedge clk) cyc++;

  mdio_fw_master u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_o(evt_o),
    .mdc_o(mdc_o), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // PHY model: bit period k (counted by MDC rises) returns data for k in 48..63
  assign mdio_i = (rises >= 48 && rises < 64) ? resp[63 - rises] : 1'b1;

  always @(posedge mdc_o) begin
    if (rises < 64) begin
      sent[rises] = mdio_o;
      drv[rises]  = mdio_oe;
    end
    rises = rises + 1;
  end

  localparam int NV = 4;
  localparam logic [5:0]  V_DIV  [NV] = '{6'd1, 6'd2, 6'd3, 6'd1};
  localparam logic [31:0] V_FRM  [NV] = '{32'h608A0000, 32'h51D61234, 32'h6FFE0000, 32'h5002FFFF};
  localparam logic [15:0] V_RSP  [NV] = '{16'hA5C3, 16'h0F0F, 16'h0001, 16'h5555};
  localparam logic [31:0] V_DATA [NV] = '{32'h608AA5C3, 32'h51D61234, 32'h6FFE0001, 32'h5002FFFF};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic wait_evt(output int n);
    n = 0;
    while (!evt_o && n < 20000) begin @(negedge clk); n++; end
  endtask

  function automatic int serial_errs(input logic [31:0] f);
    int e = 0;
    bit is_rd = (f[29:28] == 2'b10);
    for (int k = 0; k < 64; k++) begin
      logic eb = (k < 32) ? 1'b1 : f[63 - k];
      logic eo = !(is_rd && k >= 46);
      if (drv[k] !== eo) e++;
      else if (eo && sent[k] !== eb) e++;
    end
    return e;
  endfunction

  initial begin : main
    logic [31:0] r;
    int n;
    #35 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 mdc", 32'(mdc_o), 0);
    chk("R1 oe", 32'(mdio_oe), 0);
    chk("R1 evt", 32'(evt_o), 0);
    rd(2'd0, r); chk("R1 frame reg", r, 0);
    rd(2'd1, r); chk("R1 div reg", r, 0);
    rd(2'd2, r); chk("R1 evt reg", r, 0);

    // R8: divider zero inhibits start
    wr(2'd0, 32'h608A0000);
    repeat (20) @(negedge clk);
    rd(2'd2, r); chk("R8 no busy", r, 0);
    chk("R8 no mdc rise", 32'(rises), 0);
    rd(2'd0, r); chk("R8 reg unchanged", r, 0);

    // R9: divider rewrite on idle bus
    wr(2'd1, 32'd5);
    wr(2'd1, 32'd1);
    repeat (20) @(negedge clk);
    chk("R9 idle no mdc", 32'(rises), 0);
    rd(2'd1, r); chk("R9 div readback", r, 1);

    // vector table
    for (int v = 0; v < NV; v++) begin
      rises = 0; resp = V_RSP[v];
      wr(2'd1, 32'(V_DIV[v]));
      wr(2'd0, V_FRM[v]);
      rd(2'd2, r); chk("R2 busy after start", r, 32'h2);
      wait_evt(n);
      chk("R4 frame duration", 32'(n), 32'(128 * (V_DIV[v] + 1)));
      chk("R3 R5 R6 serial bits", 32'(serial_errs(V_FRM[v])), 0);
      rd(2'd0, r); chk("R5 R6 data reg", r, V_DATA[v]);
      rd(2'd2, r); chk("R7 flag set busy clear", r, 32'h1);
      wr(2'd2, 32'h0);
      chk("R7 write 0 keeps flag", 32'(evt_o), 1);
      wr(2'd2, 32'h1);
      chk("R7 write 1 clears", 32'(evt_o), 0);
    end

    // R9 + R10: mid-frame divider change and frame write are ignored for the frame
    rises = 0; resp = 16'h0;
    wr(2'd1, 32'd1);
    wr(2'd0, 32'h5002ABCD);
    repeat (10) @(negedge clk);
    wr(2'd1, 32'd7);
    wr(2'd0, 32'h6FFE0000);
    wait_evt(n);
    chk("R9 captured divider", 32'(n), 32'd256 - 32'd1 - 32'd10 - 32'd1);
    chk("R10 serial unchanged", 32'(serial_errs(32'h5002ABCD)), 0);
    rd(2'd0, r); chk("R10 reg unchanged", r, 32'h5002ABCD);
    chk("R4 mdc low after frame", 32'(mdc_o), 0);
    wr(2'd2, 32'h1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    failures++;
    $display("FAIL watchdog actual=%0d expected<150000", cyc);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule